// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a simple fixed-width processor and works out, in the same cycle, where the following instruction lives. The decode stage supplies the sign-carrying 16-bit branch displacement, the 26-bit jump field, a two-bit branch kind, a jump select and the outcome of the register equality compare. From these and the current PC the unit forms the sequential address, the PC-relative branch address and the region-preserving jump address. It then chooses one of them.

The chosen address is available combinationally on `npc_o`. It is written into the PC register on each rising clock edge while the advance enable is high. The reset input is asynchronous and active low. Its release passes through a short synchronizer before the PC may move.

Top module: `npc_sequencer`

## Requirements
- R1: After reset the PC reads 0, and it stays 0 while the advance enable is low.
- R2: With the jump select low and the branch kind 2'b00 (none), the next address is PC+4.
- R3: Branch kind 2'b01 (branch if equal) with the equality input high gives PC+4 plus the 16-bit displacement times 4.
- R4: Branch kind 2'b10 (branch if not equal) with the equality input low gives PC+4 plus the displacement times 4.
- R5: A branch whose condition fails (kind 2'b01 with equality low, or kind 2'b10 with equality high) gives PC+4.
- R6: With the jump select high, the next address is PC[31:28], then the 26-bit jump field, then two zero bits.
- R7: When the jump select is high, the jump address is chosen whatever the branch kind and equality input are.
- R8: The displacement is sign-extended before scaling, so a displacement with bit 15 set moves the PC backwards.
- R9: On a rising edge with the advance enable high the PC takes the next address; with it low the PC keeps its value.
- R10: The two low PC bits are always zero.
- R11: Branch kind 2'b11 is reserved and behaves as no branch: the next address is PC+4 for either equality value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Load the next address into the PC on this edge |
| imm_off | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Jump target field in words |
| br_kind | input | 2 | 00 none, 01 branch if equal, 10 branch if not equal, 11 reserved |
| jmp_sel | input | 1 | Select the jump address |
| ops_equal | input | 1 | The two compared registers are equal |
| pc_q | output | 32 | Current program counter |
| npc_o | output | 32 | Next instruction address |

## Verification
The PC register is the only state. A wrong value in it appears on `pc_q` at the edge where it is loaded, and it also shifts every later `npc_o` value that is built from the PC. The bench tracks the PC in its own model, so a single bad load is seen at the next sample and is still visible after any number of sequential steps. A selection fault, such as a wrong priority, a missing sign extension or a lost region splice, shows on `npc_o` in the same cycle as its inputs. The bench checks `npc_o` before each edge and `pc_q` after it, so a fault of either kind is reported within one cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_EQ   = 2'b01,
    BK_NE   = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;

  function automatic logic cond_met(br_kind_e kind, logic eq);
    logic met;
    case (kind)
      BK_EQ:   met = eq;
      BK_NE:   met = ~eq;
      default: met = 1'b0;
    endcase
    return met;
  endfunction

endpackage

// File: rtl/npc_seq_add.sv
module npc_seq_add #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] seq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  always_comb begin
    seq_o = pc_i + STEP;
  end
endmodule

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] byte_off;

  always_comb begin
    byte_off = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    tgt_o    = seq_i + byte_off;
  end
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 26
) (
  input  logic [ADDR_W-TGT_W-3:0] region_i,
  input  logic [TGT_W-1:0]        field_i,
  output logic [ADDR_W-1:0]       tgt_o
);
  always_comb begin
    tgt_o = {region_i, field_i, 2'b00};
  end
endmodule

// File: rtl/npc_pick.sv
module npc_pick
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] br_i,
  input  logic [ADDR_W-1:0] jmp_i,
  input  br_kind_e          kind_i,
  input  logic              eq_i,
  input  logic              jsel_i,
  output logic [ADDR_W-1:0] npc_o
);
  always_comb begin
    if (jsel_i) begin
      npc_o = jmp_i;
    end else if (cond_met(kind_i, eq_i)) begin
      npc_o = br_i;
    end else begin
      npc_o = seq_i;
    end
  end
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [TGT_W-1:0]  jmp_field,
  input  logic [1:0]        br_kind,
  input  logic              jmp_sel,
  input  logic              ops_equal,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] npc_o
);
  localparam int REGION_W = ADDR_W - TGT_W - 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ok;
  logic [ADDR_W-1:0]      seq_addr;
  logic [ADDR_W-1:0]      br_addr;
  logic [ADDR_W-1:0]      jmp_addr;
  logic [ADDR_W-1:0]      pc_d;
  br_kind_e               kind;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rsync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rst_pipe[s] <= 1'b0;
          else        rst_pipe[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rst_pipe[s] <= 1'b0;
          else        rst_pipe[s] <= rst_pipe[s-1];
        end
      end
    end
  endgenerate

  assign rst_ok = rst_pipe[SYNC_STAGES-1];
  assign kind   = br_kind_e'(br_kind);

  npc_seq_add #(.ADDR_W(ADDR_W)) u_seq (
    .pc_i  (pc_q),
    .seq_o (seq_addr)
  );

  npc_branch_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_br (
    .seq_i (seq_addr),
    .imm_i (imm_off),
    .tgt_o (br_addr)
  );

  npc_jump_calc #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_jmp (
    .region_i (pc_q[ADDR_W-1 -: REGION_W]),
    .field_i  (jmp_field),
    .tgt_o    (jmp_addr)
  );

  npc_pick #(.ADDR_W(ADDR_W)) u_pick (
    .seq_i  (seq_addr),
    .br_i   (br_addr),
    .jmp_i  (jmp_addr),
    .kind_i (kind),
    .eq_i   (ops_equal),
    .jsel_i (jmp_sel),
    .npc_o  (npc_o)
  );

  always_comb begin
    pc_d = pc_q;
    if (adv_en && rst_ok) pc_d = npc_o;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  // R10
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    pc_q[1:0] == 2'b00);

  // R9
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    adv_en |=> pc_q == $past(npc_o));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !adv_en |=> $stable(pc_q));

  // R6
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    jmp_sel |-> npc_o[ADDR_W-1 -: REGION_W] == pc_q[ADDR_W-1 -: REGION_W]);

  // R7
  jump_prio_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    jmp_sel |-> npc_o[TGT_W+1:0] == {jmp_field, 2'b00});

  // R2
  seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!jmp_sel && br_kind == 2'b00) |-> npc_o == pc_q + ADDR_W'(4));

endmodule

// File: tb/npc_sequencer_test.sv
module npc_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_en;
  logic [15:0] imm_off;
  logic [25:0] jmp_field;
  logic [1:0]  br_kind;
  logic        jmp_sel;
  logic        ops_equal;
  logic [31:0] pc_q;
  logic [31:0] npc_o;

  int          n_run  = 0;
  int          n_fail = 0;
  logic [31:0] exp_pc;
  bit          done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .imm_off(imm_off),
    .jmp_field(jmp_field), .br_kind(br_kind), .jmp_sel(jmp_sel),
    .ops_equal(ops_equal), .pc_q(pc_q), .npc_o(npc_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] pc, logic [15:0] imm,
      logic [25:0] tgt, logic [1:0] kind, logic js, logic eq);
    logic [31:0] seq;
    seq = pc + 32'd4;
    if (js) return {pc[31:28], tgt, 2'b00};
    if ((kind == 2'b01 && eq) || (kind == 2'b10 && !eq))
      return seq + {{14{imm[15]}}, imm, 2'b00};
    return seq;
  endfunction

  task automatic apply(string tag, logic [1:0] kind, logic js, logic eq,
      logic [15:0] imm, logic [25:0] tgt, logic adv);
    logic [31:0] want;
    @(negedge clk);
    br_kind = kind; jmp_sel = js; ops_equal = eq;
    imm_off = imm; jmp_field = tgt; adv_en = adv;
    #1;
    want = model(exp_pc, imm, tgt, kind, js, eq);
    chk({tag, " npc"}, npc_o, want);
    @(posedge clk);
    #1;
    if (adv) exp_pc = want;
    chk({tag, " pc (R9)"}, pc_q, exp_pc);
    chk("R10 align", {30'd0, pc_q[1:0]}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset pc", pc_q, 32'd0);
    chk("R2 npc from reset", npc_o, 32'd4);
    exp_pc = 32'd0;
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 3; i++) apply("R2 seq", 2'b00, 1'b0, 1'b1, 16'h7fff, 26'h1, 1'b1);
  endtask

  task automatic t_beq();
    apply("R3 beq taken", 2'b01, 1'b0, 1'b1, 16'd3, 26'h0, 1'b1);
    apply("R5 beq fall", 2'b01, 1'b0, 1'b0, 16'd40, 26'h0, 1'b1);
  endtask

  task automatic t_bne();
    apply("R4 bne taken", 2'b10, 1'b0, 1'b0, 16'd5, 26'h0, 1'b1);
    apply("R5 bne fall", 2'b10, 1'b0, 1'b1, 16'd9, 26'h0, 1'b1);
  endtask

  task automatic t_backward();
    apply("R8 back beq", 2'b01, 1'b0, 1'b1, 16'hfffe, 26'h0, 1'b1);
    apply("R8 back bne", 2'b10, 1'b0, 1'b0, 16'hfffc, 26'h0, 1'b1);
  endtask

  task automatic t_jump();
    apply("R6 jump", 2'b00, 1'b1, 1'b0, 16'h0, 26'h0000123, 1'b1);
    apply("R7 jump over beq", 2'b01, 1'b1, 1'b1, 16'h0010, 26'h0000400, 1'b1);
    apply("R7 jump over bne", 2'b10, 1'b1, 1'b0, 16'h0020, 26'h0000050, 1'b1);
  endtask

  task automatic t_region();
    apply("R6 jump top", 2'b00, 1'b1, 1'b0, 16'h0, 26'h3ffffff, 1'b1);
    apply("R2 carry region", 2'b00, 1'b0, 1'b0, 16'h0, 26'h0, 1'b1);
    chk("R6 region reached", pc_q, 32'h1000_0000);
    apply("R6 jump in region", 2'b00, 1'b1, 1'b0, 16'h0, 26'h0000005, 1'b1);
    chk("R6 spliced", pc_q, 32'h1000_0014);
  endtask

  task automatic t_hold();
    apply("R9 hold jump", 2'b00, 1'b1, 1'b0, 16'h0, 26'h0000777, 1'b0);
    apply("R9 hold beq", 2'b01, 1'b0, 1'b1, 16'h0100, 26'h0, 1'b0);
  endtask

  task automatic t_reserved();
    apply("R11 rsvd eq", 2'b11, 1'b0, 1'b1, 16'h0040, 26'h0, 1'b1);
    apply("R11 rsvd ne", 2'b11, 1'b0, 1'b0, 16'h0040, 26'h0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; adv_en = 1'b1; imm_off = '0; jmp_field = '0;
    br_kind = 2'b00; jmp_sel = 1'b0; ops_equal = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    adv_en = 1'b0;
    rst_n  = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_sequential();
    t_beq();
    t_bne();
    t_backward();
    t_jump();
    t_region();
    t_hold();
    t_reserved();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule